// File: doc/BRIEF.md
# Palette DAC Register Interface

This block is the host-facing side of a colour lookup table in a video DAC. The host reaches four 32-bit registers over a single write channel. The first register sets the palette index. The second takes colour-map data. The third holds the mode bit. The fourth takes cursor-colour data. Colour data advances through the table on its own, one component at a time. In byte mode each write carries one component. In packed mode each write carries four component bytes.

On the other side, the pixel pipeline presents an 8-bit index and receives the matching 24-bit colour on the next cycle. A flag on the same port selects one of the small cursor colour entries instead of the palette.

The host channel uses valid/ready. `wr_ready` is low during reset and high from the first clock after it. A write takes effect only in a cycle where `wr_valid` and `wr_ready` are both high. The lookup port has no back-pressure. The pipeline must take `rgb_data` in the cycle that `rgb_valid` is high.

Top module: `pdac_regif`

## Requirements
- R1: Out of reset, every palette and cursor entry reads black (0x000000), the block is in byte mode, `rgb_valid` is low, and `wr_ready` is high from the first clock after reset.
- R2: A write with `wr_sel`=0 loads the palette index from `wr_data[31:24]`. Bits 23:0 are ignored.
- R3: In byte mode, a write with `wr_sel`=1 stores `wr_data[31:24]` as one component. Successive writes store red, then green, then blue. Bits 23:0 are ignored.
- R4: In packed mode, one `wr_sel`=1 write stores four components in sequence, taken from bytes 31:24, 23:16, 15:8 and 7:0 in that order. Three words therefore fill four entries. An address written while in packed mode has its two low bits forced to zero.
- R5: Writing the address register or the control register returns the component counter to red.
- R6: After a blue component is stored, the index advances by one. It wraps from 255 to 0.
- R7: Control register (`wr_sel`=2) bit 0 selects the mode: 0 is byte mode and 1 is packed mode. The reset value is 0.
- R8: A lookup presented with `pix_valid` high returns `rgb_valid` high with the colour, packed as 0xRRGGBB, on the next cycle. `rgb_valid` is low after any cycle with no lookup. A host write accepted before the lookup cycle is visible to that lookup.
- R9: Three all-ones byte-mode writes after setting the index to 0 make entry 0 white (0xFFFFFF).
- R10: A `wr_sel`=3 write stores `wr_data[31:24]` as one component of cursor entry `index[1:0]`. It uses the same component counter and index advance as byte mode, and it leaves the palette unchanged. A lookup with `pix_cursor` high returns cursor entry `pix_index[1:0]`.
- R11: A write presented with `wr_valid` low changes neither the table nor the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Host write can be accepted |
| wr_sel | input | 2 | Register select: 0 address, 1 palette data, 2 control, 3 cursor data |
| wr_data | input | 32 | Host write data |
| pix_valid | input | 1 | Lookup request |
| pix_cursor | input | 1 | Lookup targets a cursor colour |
| pix_index | input | 8 | Lookup index |
| rgb_valid | output | 1 | Lookup result valid |
| rgb_data | output | 24 | Lookup colour, red in bits 23:16 |

## Verification
The assertions check several properties on every cycle:
- the component counter never takes its unused value;
- an address write clears the counter;
- an address write in packed mode leaves the index aligned;
- the final blue write at index 255 wraps the index to 0;
- `rgb_valid` follows `pix_valid` by exactly one cycle.

Only the directed scenarios can show that colour bytes land in the correct entry and component:
- byte-lane order in packed mode;
- the white restore;
- cursor entries leaving the palette untouched;
- writes with `wr_valid` low being ignored;
- visibility of a write to the lookup that follows it.

// File: rtl/pdac_pkg.sv
package pdac_pkg;
  localparam int COMP_W = 8;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_PAL  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_CUR  = 2'd3
  } reg_sel_e;

  localparam logic [1:0] COMP_RED = 2'd0;
  localparam logic [1:0] COMP_GRN = 2'd1;
  localparam logic [1:0] COMP_BLU = 2'd2;

  typedef struct packed {
    logic [COMP_W-1:0] r;
    logic [COMP_W-1:0] g;
    logic [COMP_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/pdac_seq.sv
module pdac_seq
  import pdac_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int BUS_W = 32,
  parameter int CUR_W = 2,
  parameter int LANES = BUS_W / COMP_W
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                acc,
  input  reg_sel_e                            sel,
  input  logic [BUS_W-1:0]                    data,
  output logic [LANES-1:0]                    lane_we,
  output logic [LANES-1:0][IDX_W-1:0]         lane_idx,
  output logic [LANES-1:0][1:0]               lane_comp,
  output logic [LANES-1:0][COMP_W-1:0]        lane_byte,
  output logic                                cur_we,
  output logic [CUR_W-1:0]                    cur_idx,
  output logic [1:0]                          cur_comp,
  output logic [COMP_W-1:0]                   cur_byte
);
  localparam int ALN_W = $clog2(LANES);

  logic [IDX_W-1:0] idx_q;
  logic [1:0]       sub_q;
  logic             packed_q;

  logic [IDX_W-1:0] ch_e [LANES+1];
  logic [1:0]       ch_s [LANES+1];
  logic [IDX_W-1:0] addr_new;

  assign ch_e[0] = idx_q;
  assign ch_s[0] = sub_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign ch_e[k+1]    = (ch_s[k] == COMP_BLU) ? ch_e[k] + 1'b1 : ch_e[k];
    assign ch_s[k+1]    = (ch_s[k] == COMP_BLU) ? COMP_RED : ch_s[k] + 2'd1;
    assign lane_we[k]   = acc && (sel == SEL_PAL) && ((k == 0) || packed_q);
    assign lane_idx[k]  = ch_e[k];
    assign lane_comp[k] = ch_s[k];
    assign lane_byte[k] = data[BUS_W-1-k*COMP_W -: COMP_W];
  end

  assign cur_we   = acc && (sel == SEL_CUR);
  assign cur_idx  = idx_q[CUR_W-1:0];
  assign cur_comp = sub_q;
  assign cur_byte = data[BUS_W-1 -: COMP_W];

  always_comb begin
    addr_new = data[BUS_W-1 -: IDX_W];
    if (packed_q) addr_new[ALN_W-1:0] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      sub_q    <= COMP_RED;
      packed_q <= 1'b0;
    end else if (acc) begin
      case (sel)
        SEL_ADDR: begin
          idx_q <= addr_new;
          sub_q <= COMP_RED;
        end
        SEL_CTRL: begin
          packed_q <= data[0];
          sub_q    <= COMP_RED;
        end
        SEL_PAL: begin
          if (packed_q) begin
            idx_q <= ch_e[LANES];
            sub_q <= ch_s[LANES];
          end else begin
            idx_q <= ch_e[1];
            sub_q <= ch_s[1];
          end
        end
        default: begin
          idx_q <= ch_e[1];
          sub_q <= ch_s[1];
        end
      endcase
    end
  end

  AST_SUB_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    sub_q != 2'd3); // R3
  AST_PACKED_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sel == SEL_ADDR && packed_q) |=> (idx_q[ALN_W-1:0] == '0)); // R4
  AST_ADDR_CLEARS_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sel == SEL_ADDR) |=> (sub_q == COMP_RED)); // R5
  AST_INDEX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sel == SEL_PAL && !packed_q && idx_q == '1 && sub_q == COMP_BLU)
      |=> (idx_q == '0)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(idx_q) && $stable(sub_q))); // R11
endmodule

// File: rtl/pdac_store.sv
module pdac_store
  import pdac_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int LANES = 4,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LANES-1:0]              we,
  input  logic [LANES-1:0][IDX_W-1:0]   widx,
  input  logic [LANES-1:0][1:0]         wcomp,
  input  logic [LANES-1:0][COMP_W-1:0]  wbyte,
  input  logic                          rd_en,
  input  logic [IDX_W-1:0]              rd_idx,
  output rgb_t                          rd_q
);
  logic [COMP_W-1:0] red_m [ENTRIES];
  logic [COMP_W-1:0] grn_m [ENTRIES];
  logic [COMP_W-1:0] blu_m [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        red_m[i] <= '0;
        grn_m[i] <= '0;
        blu_m[i] <= '0;
      end
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (we[k]) begin
          case (wcomp[k])
            COMP_RED: red_m[widx[k]] <= wbyte[k];
            COMP_GRN: grn_m[widx[k]] <= wbyte[k];
            default:  blu_m[widx[k]] <= wbyte[k];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= '0;
    else if (rd_en) rd_q <= '{r: red_m[rd_idx], g: grn_m[rd_idx], b: blu_m[rd_idx]};
  end

  AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q)); // R8
endmodule

// File: rtl/pdac_curs.sv
module pdac_curs
  import pdac_pkg::*;
#(
  parameter int CUR_W = 2,
  localparam int CUR_N = 1 << CUR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CUR_W-1:0]  widx,
  input  logic [1:0]        wcomp,
  input  logic [COMP_W-1:0] wbyte,
  input  logic              rd_en,
  input  logic [CUR_W-1:0]  rd_idx,
  output rgb_t              rd_q
);
  rgb_t ent [CUR_N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CUR_N; i++) ent[i] <= '0;
      rd_q <= '0;
    end else begin
      if (we) begin
        case (wcomp)
          COMP_RED: ent[widx].r <= wbyte;
          COMP_GRN: ent[widx].g <= wbyte;
          default:  ent[widx].b <= wbyte;
        endcase
      end
      if (rd_en) rd_q <= ent[rd_idx];
    end
  end
endmodule

// File: rtl/pdac_regif.sv
module pdac_regif
  import pdac_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int BUS_W = 32,
  parameter int CUR_W = 2,
  localparam int LANES = BUS_W / COMP_W,
  localparam int RGB_W = 3 * COMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [1:0]       wr_sel,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             pix_valid,
  input  logic             pix_cursor,
  input  logic [IDX_W-1:0] pix_index,
  output logic             rgb_valid,
  output logic [RGB_W-1:0] rgb_data
);
  logic rdy_q, acc, vld_q, cur_sel_q;
  reg_sel_e sel;

  logic [LANES-1:0]                   lane_we;
  logic [LANES-1:0][IDX_W-1:0]        lane_idx;
  logic [LANES-1:0][1:0]              lane_comp;
  logic [LANES-1:0][COMP_W-1:0]       lane_byte;
  logic                               cur_we;
  logic [CUR_W-1:0]                   cur_idx;
  logic [1:0]                         cur_comp;
  logic [COMP_W-1:0]                  cur_byte;
  rgb_t                               pal_q, curs_q;

  assign sel      = reg_sel_e'(wr_sel);
  assign wr_ready = rdy_q;
  assign acc      = wr_valid && rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q     <= 1'b0;
      vld_q     <= 1'b0;
      cur_sel_q <= 1'b0;
    end else begin
      rdy_q     <= 1'b1;
      vld_q     <= pix_valid;
      if (pix_valid) cur_sel_q <= pix_cursor;
    end
  end

  pdac_seq #(.IDX_W(IDX_W), .BUS_W(BUS_W), .CUR_W(CUR_W), .LANES(LANES)) u_seq (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sel(sel), .data(wr_data),
    .lane_we(lane_we), .lane_idx(lane_idx), .lane_comp(lane_comp), .lane_byte(lane_byte),
    .cur_we(cur_we), .cur_idx(cur_idx), .cur_comp(cur_comp), .cur_byte(cur_byte)
  );

  pdac_store #(.IDX_W(IDX_W), .LANES(LANES)) u_store (
    .clk(clk), .rst_n(rst_n), .we(lane_we), .widx(lane_idx), .wcomp(lane_comp),
    .wbyte(lane_byte), .rd_en(pix_valid && !pix_cursor), .rd_idx(pix_index), .rd_q(pal_q)
  );

  pdac_curs #(.CUR_W(CUR_W)) u_curs (
    .clk(clk), .rst_n(rst_n), .we(cur_we), .widx(cur_idx), .wcomp(cur_comp),
    .wbyte(cur_byte), .rd_en(pix_valid && pix_cursor), .rd_idx(pix_index[CUR_W-1:0]),
    .rd_q(curs_q)
  );

  assign rgb_valid = vld_q;
  assign rgb_data  = cur_sel_q ? curs_q : pal_q;

  AST_LOOKUP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> rgb_valid); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !rgb_valid); // R8
endmodule

// File: tb/pdac_regif_test.sv
module pdac_regif_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        pix_valid = 1'b0;
  logic        pix_cursor = 1'b0;
  logic [7:0]  pix_index = '0;
  logic        rgb_valid;
  logic [23:0] rgb_data;

  int n_run = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pdac_regif uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .pix_valid(pix_valid),
    .pix_cursor(pix_cursor), .pix_index(pix_index),
    .rgb_valid(rgb_valid), .rgb_data(rgb_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] s, input logic [31:0] d);
    wr_valid = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_data = '0;
  endtask

  task automatic look(input logic cur, input logic [7:0] ix, input logic [23:0] exp, input string req);
    pix_valid = 1'b1; pix_cursor = cur; pix_index = ix;
    @(negedge clk);
    pix_valid = 1'b0; pix_cursor = 1'b0;
    chk(req, {31'd0, rgb_valid}, 32'd1);
    chk(req, {8'd0, rgb_data}, {8'd0, exp});
  endtask

  task automatic t_reset;
    chk("R1 ready", {31'd0, wr_ready}, 32'd1);
    chk("R1 valid idle", {31'd0, rgb_valid}, 32'd0);
    look(1'b0, 8'd0, 24'h000000, "R1 entry0");
    look(1'b0, 8'd255, 24'h000000, "R1 entry255");
    look(1'b1, 8'd3, 24'h000000, "R1 cursor3");
  endtask

  task automatic t_byte_mode;
    host_wr(2'd0, 32'h05ABCDEF);                  // R2 low bits ignored
    host_wr(2'd1, 32'h11FFFFFF);
    host_wr(2'd1, 32'h22000000);
    host_wr(2'd1, 32'h33123456);
    host_wr(2'd1, 32'h44000000);
    host_wr(2'd1, 32'h55000000);
    host_wr(2'd1, 32'h66000000);
    look(1'b0, 8'd5, 24'h112233, "R2 R3 entry5");
    look(1'b0, 8'd6, 24'h445566, "R6 advance entry6");
  endtask

  task automatic t_wrap;
    host_wr(2'd0, 32'hFF000000);
    host_wr(2'd1, 32'h01000000);
    host_wr(2'd1, 32'h02000000);
    host_wr(2'd1, 32'h03000000);
    host_wr(2'd1, 32'h0A000000);
    host_wr(2'd1, 32'h0B000000);
    host_wr(2'd1, 32'h0C000000);
    look(1'b0, 8'd255, 24'h010203, "R6 entry255");
    look(1'b0, 8'd0, 24'h0A0B0C, "R6 wrap to 0");
  endtask

  task automatic t_white;
    host_wr(2'd0, 32'h00000000);
    host_wr(2'd1, 32'hFFFFFFFF);
    host_wr(2'd1, 32'hFFFFFFFF);
    host_wr(2'd1, 32'hFFFFFFFF);
    look(1'b0, 8'd0, 24'hFFFFFF, "R9 white");
  endtask

  task automatic t_addr_resets_sub;
    host_wr(2'd0, 32'h0A000000);
    host_wr(2'd1, 32'h77000000);
    host_wr(2'd0, 32'h0A000000);
    host_wr(2'd1, 32'h01000000);
    host_wr(2'd1, 32'h02000000);
    host_wr(2'd1, 32'h03000000);
    look(1'b0, 8'd10, 24'h010203, "R5 restart at red");
  endtask

  task automatic t_packed;
    host_wr(2'd2, 32'h00000001);                  // R7 packed on
    host_wr(2'd0, 32'h0B000000);                  // R4 aligned to 8
    host_wr(2'd1, 32'h10203040);
    host_wr(2'd1, 32'h50607080);
    host_wr(2'd1, 32'h90A0B0C0);
    look(1'b0, 8'd8,  24'h102030, "R4 R7 entry8");
    look(1'b0, 8'd9,  24'h405060, "R4 entry9");
    look(1'b0, 8'd10, 24'h708090, "R4 entry10");
    look(1'b0, 8'd11, 24'hA0B0C0, "R4 entry11");
    look(1'b0, 8'd12, 24'h000000, "R4 entry12 untouched");
    host_wr(2'd2, 32'h00000000);                  // back to byte mode
  endtask

  task automatic t_ignore;
    host_wr(2'd0, 32'h14000000);
    wr_valid = 1'b0; wr_sel = 2'd1; wr_data = 32'hEE000000;
    @(negedge clk);
    wr_data = '0;
    host_wr(2'd1, 32'h01000000);
    host_wr(2'd1, 32'h02000000);
    host_wr(2'd1, 32'h03000000);
    look(1'b0, 8'd20, 24'h010203, "R11 idle write ignored");
  endtask

  task automatic t_cursor;
    host_wr(2'd0, 32'h02000000);
    host_wr(2'd3, 32'hAA000000);
    host_wr(2'd3, 32'hBB000000);
    host_wr(2'd3, 32'hCC000000);
    look(1'b1, 8'd2, 24'hAABBCC, "R10 cursor2");
    look(1'b0, 8'd2, 24'h000000, "R10 palette2 untouched");
  endtask

  task automatic t_latency;
    host_wr(2'd0, 32'h30000000);
    host_wr(2'd1, 32'h12000000);
    host_wr(2'd1, 32'h34000000);
    host_wr(2'd1, 32'h56000000);
    look(1'b0, 8'd48, 24'h123456, "R8 write visible next lookup");
    @(negedge clk);
    chk("R8 valid drops", {31'd0, rgb_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_mode();
    t_wrap();
    t_white();
    t_addr_resets_sub();
    t_packed();
    t_ignore();
    t_cursor();
    t_latency();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_run++;
      n_bad++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule